// File: doc/BRIEF.md
# Ethernet Transmit Retry Controller

This block sequences the transmission attempts of one outgoing Ethernet frame. Once a frame starts it watches the collision report from the MAC and, for each collision, either requests a retransmission of the frame from its beginning or gives up with a retry error. A clean end of the frame produces a done strobe. While a replay may still be needed, it tells the transmit FIFO to keep the head of the frame.

Two configuration bits shape the behaviour. The single-attempt bit cuts the retry budget from sixteen attempts to one, and it also turns off the FIFO head protection. The forced-collision bit is a test aid. While the MAC is in internal loopback, it makes every attempt collide. Both bits are held in local registers that only accept a write while the halt or the pause input is high. Backoff timing, carrier sense and the FIFO storage are handled elsewhere.

Top module: `txr_retry_ctrl`

## Requirements
- R1: After reset the controller is idle, and `retry_req`, `fifo_hold`, `done` and `retry_err` are all 0.
- R2: With the single-attempt bit at 0, a frame may make up to 16 attempts. Each collision on attempts 1 to 15 that falls inside the protect window gives one `retry_req` pulse. A collision on attempt 16 gives a `retry_err` pulse and ends the frame.
- R3: With the single-attempt bit at 1, the first collision gives `retry_err` and no `retry_req` pulse ever occurs.
- R4: With the single-attempt bit at 0, `fifo_hold` goes high in the cycle after the accepted frame start. It drops in the cycle after the 64th `byte_sent` of the current attempt, or when the frame ends in either way. With the single-attempt bit at 1, `fifo_hold` stays low.
- R5: While the forced-collision bit and `loop_internal` are both 1, every cycle of an attempt is treated as a collision, so the frame ends with `retry_err` after the full attempt budget.
- R6: If the forced-collision bit is 0 or `loop_internal` is 0, the forced-collision logic has no effect, and a frame with no collision ends with `done`.
- R7: A configuration write (`cfg_we` high) is taken only in a cycle in which `halt` or `pause` is high. At any other time it is ignored and both configuration bits keep their values.
- R8: A collision after the 64th `byte_sent` of the current attempt is a late collision. It gives `retry_err` and no `retry_req`, whatever attempts remain.
- R9: The attempt counter restarts at each accepted frame start, so each new frame gets the full attempt budget.
- R10: `done` and `retry_err` are single-cycle pulses and never high together. If a collision and `frame_end` arrive in the same cycle, the collision takes priority.
- R11: A `frame_start` that arrives while a frame is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Starts a new frame; accepted only while idle |
| byte_sent | input | 1 | One frame byte left the FIFO this cycle |
| frame_end | input | 1 | Current attempt finished without collision |
| collision | input | 1 | Collision reported by the MAC |
| loop_internal | input | 1 | MAC is in internal loopback |
| halt | input | 1 | Stop state; opens configuration writes |
| pause | input | 1 | Suspend state; opens configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_no_retry | input | 1 | Write data for the single-attempt bit |
| cfg_force_coll | input | 1 | Write data for the forced-collision bit |
| retry_req | output | 1 | Pulse: replay the frame from its start |
| fifo_hold | output | 1 | Keep the frame head in the transmit FIFO |
| done | output | 1 | Pulse: frame sent |
| retry_err | output | 1 | Pulse: frame abandoned |

## Verification
Every output is registered. The effect of any input sampled at a rising edge shows on the outputs right after that edge, one cycle after the input was driven. A configuration write changes behaviour from the following edge onward. The bench drives inputs on falling edges and keeps a behavioural model that steps on the same rising edge. It compares all four outputs a few nanoseconds after every rising edge, so every pulse is checked in the single cycle it is due. Per-scenario pulse totals, and level checks of `fifo_hold` taken one and sixty-five cycles after a start, cover the named corner cases.

// File: rtl/txr_pkg.sv
package txr_pkg;

   typedef enum logic {
      TXR_IDLE = 1'b0,
      TXR_SEND = 1'b1
   } txr_state_e;

   typedef struct packed {
      logic no_retry;
      logic force_coll;
   } txr_cfg_t;

endpackage

// File: rtl/txr_cfg_gate.sv
module txr_cfg_gate
   import txr_pkg::*;
#(
   parameter bit FORCE_COLL_EN = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     halt,
   input  logic     pause,
   input  logic     we,
   input  logic     wr_no_retry,
   input  logic     wr_force_coll,
   output txr_cfg_t cfg
);

   logic unlocked;
   logic no_retry_q;
   logic force_q;

   assign unlocked = halt | pause;

   always_ff @(posedge clk) begin
      if (!rst_n)                no_retry_q <= 1'b0;
      else if (we && unlocked)   no_retry_q <= wr_no_retry;
   end

   generate
      if (FORCE_COLL_EN) begin : g_force
         always_ff @(posedge clk) begin
            if (!rst_n)              force_q <= 1'b0;
            else if (we && unlocked) force_q <= wr_force_coll;
         end
      end else begin : g_no_force
         logic unused_force_wr;
         assign unused_force_wr = wr_force_coll;
         assign force_q = 1'b0;
      end
   endgenerate

   assign cfg.no_retry   = no_retry_q;
   assign cfg.force_coll = force_q;

   // R7: configuration holds when neither halt nor pause is high
   assert_cfg_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(halt || pause) |=> $stable(cfg));

endmodule

// File: rtl/txr_try_ctr.sv
module txr_try_ctr #(
   parameter int MAX_TRIES = 16,
   localparam int CW = $clog2(MAX_TRIES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          incr,
   input  logic          single,
   output logic [CW-1:0] count,
   output logic          at_limit
);

   localparam logic [CW-1:0] LIMIT = CW'(MAX_TRIES);
   localparam logic [CW-1:0] ONE   = CW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)                 count <= '0;
      else if (load)              count <= ONE;
      else if (incr && !at_limit) count <= count + ONE;
   end

   assign at_limit = single | (count >= LIMIT);

   // R2: attempt count never runs past the budget
   assert_try_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= LIMIT);

   // R9: a load always restarts the count at the first attempt
   assert_try_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count == ONE));

endmodule

// File: rtl/txr_byte_win.sv
module txr_byte_win #(
   parameter int WINDOW = 64,
   localparam int BW = $clog2(WINDOW + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic full,
   output logic last_step
);

   localparam logic [BW-1:0] TOP  = BW'(WINDOW);
   localparam logic [BW-1:0] LAST = BW'(WINDOW - 1);

   logic [BW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (clear)        cnt <= '0;
      else if (step && !full) cnt <= cnt + BW'(1);
   end

   assign full      = (cnt == TOP);
   assign last_step = step && (cnt == LAST);

   // R8: the byte count saturates at the window size
   assert_win_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= TOP);

endmodule

// File: rtl/txr_retry_ctrl.sv
module txr_retry_ctrl
   import txr_pkg::*;
#(
   parameter int MAX_TRIES     = 16,
   parameter int WINDOW        = 64,
   parameter bit FORCE_COLL_EN = 1'b1,
   localparam int CW = $clog2(MAX_TRIES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start,
   input  logic byte_sent,
   input  logic frame_end,
   input  logic collision,
   input  logic loop_internal,
   input  logic halt,
   input  logic pause,
   input  logic cfg_we,
   input  logic cfg_no_retry,
   input  logic cfg_force_coll,
   output logic retry_req,
   output logic fifo_hold,
   output logic done,
   output logic retry_err
);

   generate
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("txr_retry_ctrl: MAX_TRIES must be at least 1");
      end
      if (WINDOW < 1) begin : g_bad_window
         $error("txr_retry_ctrl: WINDOW must be at least 1");
      end
   endgenerate

   txr_state_e    state;
   txr_cfg_t      cfg;
   logic [CW-1:0] tries;
   logic          at_limit;
   logic          win_full;
   logic          win_last;

   logic busy, accept, coll_eff, hit, abort_now, rearm, finish, step;

   txr_cfg_gate #(.FORCE_COLL_EN(FORCE_COLL_EN)) u_cfg (
      .clk           (clk),
      .rst_n         (rst_n),
      .halt          (halt),
      .pause         (pause),
      .we            (cfg_we),
      .wr_no_retry   (cfg_no_retry),
      .wr_force_coll (cfg_force_coll),
      .cfg           (cfg)
   );

   assign busy      = (state == TXR_SEND);
   assign accept    = (state == TXR_IDLE) && frame_start;
   assign coll_eff  = collision | (cfg.force_coll & loop_internal);
   assign hit       = busy && coll_eff;
   assign abort_now = hit && (win_full || at_limit);
   assign rearm     = hit && !abort_now;
   assign finish    = busy && !coll_eff && frame_end;
   assign step      = busy && !coll_eff && !frame_end && byte_sent;

   txr_try_ctr #(.MAX_TRIES(MAX_TRIES)) u_tries (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .incr     (rearm),
      .single   (cfg.no_retry),
      .count    (tries),
      .at_limit (at_limit)
   );

   txr_byte_win #(.WINDOW(WINDOW)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (accept | rearm),
      .step      (step),
      .full      (win_full),
      .last_step (win_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= TXR_IDLE;
         retry_req <= 1'b0;
         done      <= 1'b0;
         retry_err <= 1'b0;
         fifo_hold <= 1'b0;
      end else begin
         retry_req <= rearm;
         done      <= finish;
         retry_err <= abort_now;
         if (accept)                  state <= TXR_SEND;
         else if (abort_now || finish) state <= TXR_IDLE;
         if (accept)                  fifo_hold <= !cfg.no_retry;
         else if (abort_now || finish) fifo_hold <= 1'b0;
         else if (win_last)           fifo_hold <= 1'b0;
      end
   end

   // R10: end strobes are exclusive and last one cycle
   assert_end_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && retry_err));
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      retry_err |=> !retry_err);

   // R3: no replay request while single-attempt mode was active
   assert_single_no_replay_R3: assert property (@(posedge clk) disable iff (!rst_n)
      retry_req |-> !$past(cfg.no_retry));

   // R4: protection only starts with retries enabled
   assert_hold_needs_retry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fifo_hold) |-> !$past(cfg.no_retry));

   // R8: no replay once the window has been passed
   assert_late_no_replay_R8: assert property (@(posedge clk) disable iff (!rst_n)
      retry_req |-> !$past(win_full));

   // R5: forced collision in loopback ends every busy cycle with replay or error
   assert_forced_coll_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cfg.force_coll && loop_internal) |=> (retry_req || retry_err));

   // R11: a start while busy does not reload the attempt counter
   assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && frame_start && !hit) |=> $stable(tries));

endmodule

// File: tb/sim_txr_retry_ctrl.sv
module sim_txr_retry_ctrl;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_start = 0, byte_sent = 0, frame_end = 0, collision = 0;
   logic loop_internal = 0, halt = 0, pause = 0;
   logic cfg_we = 0, cfg_no_retry = 0, cfg_force_coll = 0;
   logic retry_req, fifo_hold, done, retry_err;

   always #5 clk = ~clk;

   txr_retry_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_sent(byte_sent),
      .frame_end(frame_end), .collision(collision), .loop_internal(loop_internal),
      .halt(halt), .pause(pause), .cfg_we(cfg_we), .cfg_no_retry(cfg_no_retry),
      .cfg_force_coll(cfg_force_coll), .retry_req(retry_req), .fifo_hold(fifo_hold),
      .done(done), .retry_err(retry_err)
   );

   int checks = 0, fails = 0, cycles = 0;
   int n_retry = 0, n_done = 0, n_err = 0;
   string cur_req = "R1";

   // behavioural reference model
   bit m_busy, m_hold, m_retry, m_done, m_err, m_noret, m_force;
   int m_tries, m_bytes, m_lim;
   bit m_ce;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_hold = 0; m_retry = 0; m_done = 0; m_err = 0;
         m_noret = 0; m_force = 0; m_tries = 0; m_bytes = 0;
      end else begin
         m_retry = 0; m_done = 0; m_err = 0;
         m_ce = collision || (m_force && loop_internal);
         if (!m_busy) begin
            if (frame_start) begin
               m_busy = 1; m_tries = 1; m_bytes = 0; m_hold = !m_noret;
            end
         end else if (m_ce) begin
            m_lim = m_noret ? 1 : 16;
            if (m_bytes >= 64 || m_tries >= m_lim) begin
               m_err = 1; m_busy = 0; m_hold = 0;
            end else begin
               m_retry = 1; m_tries++; m_bytes = 0;
            end
         end else if (frame_end) begin
            m_done = 1; m_busy = 0; m_hold = 0;
         end else if (byte_sent && m_bytes < 64) begin
            m_bytes++;
            if (m_bytes == 64) m_hold = 0;
         end
         if (cfg_we && (halt || pause)) begin
            m_noret = cfg_no_retry; m_force = cfg_force_coll;
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // per-cycle comparison, away from the edge
   always @(posedge clk) begin
      #3;
      if (rst_n) begin
         check(cur_req, {retry_req, fifo_hold, done, retry_err},
               {m_retry, m_hold, m_done, m_err});
         if (retry_req) n_retry++;
         if (done)      n_done++;
         if (retry_err) n_err++;
      end
   end

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected below 50000 cycles", cycles);
         report();
      end
   end

   task automatic cyc(input logic fs, input logic bs, input logic fe, input logic co);
      @(negedge clk);
      frame_start = fs; byte_sent = bs; frame_end = fe; collision = co;
   endtask

   task automatic idle(input int n);
      repeat (n) cyc(0, 0, 0, 0);
   endtask

   task automatic bytes(input int n);
      repeat (n) cyc(0, 1, 0, 0);
   endtask

   task automatic wcfg(input logic h, input logic p, input logic nr, input logic fc);
      @(negedge clk);
      halt = h; pause = p; cfg_we = 1; cfg_no_retry = nr; cfg_force_coll = fc;
      @(negedge clk);
      halt = 0; pause = 0; cfg_we = 0;
   endtask

   task automatic clr();
      idle(2);
      n_retry = 0; n_done = 0; n_err = 0;
   endtask

   task automatic totals(input string req, input int r, input int d, input int e);
      check({req, " retry"}, n_retry, r);
      check({req, " done"},  n_done, d);
      check({req, " err"},   n_err, e);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      cur_req = "R1";
      check("R1 outputs", {retry_req, fifo_hold, done, retry_err}, 0);

      // R6, R4: clean frame, protect window drops after byte 64
      cur_req = "R4"; clr();
      cyc(1, 0, 0, 0); cyc(0, 0, 0, 0);
      check("R4 hold after start", fifo_hold, 1);
      bytes(64); cyc(0, 0, 0, 0);
      check("R4 hold after byte 64", fifo_hold, 0);
      bytes(6); cyc(0, 0, 1, 0); idle(3);
      totals("R6", 0, 1, 0);

      // R2: sixteen attempts, then retry error
      cur_req = "R2"; clr();
      cyc(1, 0, 0, 0);
      for (int i = 0; i < 15; i++) begin bytes(5); cyc(0, 0, 0, 1); end
      bytes(5); cyc(0, 0, 0, 1); idle(3);
      totals("R2", 15, 0, 1);

      // R9: a fresh frame starts a fresh budget
      cur_req = "R9"; clr();
      cyc(1, 0, 0, 0);
      for (int i = 0; i < 15; i++) begin bytes(2); cyc(0, 0, 0, 1); end
      bytes(3); cyc(0, 0, 1, 0); idle(3);
      totals("R9", 15, 1, 0);

      // R8: collision after the window is late
      cur_req = "R8"; clr();
      cyc(1, 0, 0, 0); bytes(64); cyc(0, 0, 0, 1); idle(3);
      totals("R8", 0, 0, 1);

      // R7: write without halt or pause is ignored (retries stay on)
      cur_req = "R7"; clr();
      wcfg(0, 0, 1, 0);
      cyc(1, 0, 0, 0); cyc(0, 0, 0, 0);
      check("R7 hold still on", fifo_hold, 1);
      bytes(3); cyc(0, 0, 0, 1); bytes(3); cyc(0, 0, 1, 0); idle(3);
      totals("R7", 1, 1, 0);

      // R3: single attempt via halt
      cur_req = "R3"; clr();
      wcfg(1, 0, 1, 0);
      cyc(1, 0, 0, 0); cyc(0, 0, 0, 0);
      check("R3 hold off", fifo_hold, 0);
      bytes(4); cyc(0, 0, 0, 1); idle(3);
      totals("R3", 0, 0, 1);

      // R5: forced collision in internal loopback, written under pause
      cur_req = "R5"; clr();
      wcfg(0, 1, 0, 1);
      loop_internal = 1;
      cyc(1, 0, 0, 0); idle(22);
      totals("R5", 15, 0, 1);

      // R6: forced bit set but loopback off
      cur_req = "R6"; clr();
      loop_internal = 0;
      cyc(1, 0, 0, 0); bytes(10); cyc(0, 0, 1, 0); idle(3);
      totals("R6 no loopback", 0, 1, 0);
      wcfg(1, 0, 0, 0);

      // R11: second start while busy ignored
      cur_req = "R11"; clr();
      cyc(1, 0, 0, 0); bytes(3); cyc(1, 0, 0, 0); bytes(3);
      cyc(0, 0, 1, 0); idle(3);
      totals("R11", 0, 1, 0);

      // R10: collision beats frame end in the same cycle
      cur_req = "R10"; clr();
      cyc(1, 0, 0, 0); bytes(2); cyc(0, 0, 1, 1); idle(2);
      check("R10 no done on tie", n_done, 0);
      check("R10 replay on tie", n_retry, 1);
      cyc(0, 0, 1, 0); idle(3);
      totals("R10", 1, 1, 0);

      report();
   end

endmodule